// File: doc/BRIEF.md
# Charger Status and Interrupt Indicator

This block drives the two open-drain indicator lines of a battery charger: one line lights a status LED, the other signals the host. It produces pull-down enables for both pads (the pads themselves are outside the block). Both lines carry the same information. The block also keeps a 2-bit charge-state code and a 3-bit fault code that a register interface can read.

A steady low on both lines means a charge is in progress. This only happens while the status-enable bit is set, and that bit comes out of reset at 1. When a fault input rises, both lines are pulled low for a fixed pulse of `PULSE_CYCLES` clock cycles. After the pulse they float again. The default of 6400 cycles gives 128 µs at 50 MHz.

Only a rising edge starts a pulse. A fault that stays active does not start another one. A new edge that arrives during a pulse reloads the full width. While any fault input is high, the state code reads 11 and the fault code names the fault with the highest priority. Once every fault is gone, both codes return to their normal values on their own.

Top module: `chg_stat_out`

## Requirements
- R1: During and right after reset, both pull-down enables are 0, the state code is 00, the fault code is 000 and the status-enable bit is 1.
- R2: With no pulse running, both lines are pulled down exactly when the registered state code is 01 (charging) and status enable is 1. In ready (phase input 00) and done (phase input 10) the lines float.
- R3: A write strobe (`statEnWrite` high at a clock edge) loads `statEnData` into the status-enable bit. With the bit at 0, charging leaves both lines floating.
- R4: One clock after the inputs are sampled, the state code equals the phase input (00 ready, 01 charging, 10 done). It reads 11 whenever any fault input is high.
- R5: The fault code is 000 when no fault is high. Otherwise it names the highest-priority active input: bit 0 over-voltage gives 001, bit 1 sleep 010, bit 2 input undervoltage or faulty adapter 011, bit 3 thermal shutdown 100, bit 4 safety timer 101. Bit 0 has the highest priority.
- R6: A rising edge on any fault input pulls both lines low from the next clock for exactly `PULSE_CYCLES` cycles, whatever the status-enable bit says.
- R7: A fault input that stays high starts no further pulse. After its pulse ends, the lines float unless R2 pulls them down.
- R8: A rising edge during a running pulse restarts that pulse at its full width.
- R9: When every fault input has cleared, the state and fault codes return to the phase input and 000 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseIn | input | 2 | Charge phase: 00 ready, 01 charging, 10 done |
| faultIn | input | 5 | Fault levels: over-voltage, sleep, undervoltage/adapter, thermal, timer (bit 0 to bit 4) |
| statEnWrite | input | 1 | Write strobe for the status-enable bit |
| statEnData | input | 1 | Value written to the status-enable bit |
| ledPullDown | output | 1 | Pull-down enable for the LED status pad |
| irqPullDown | output | 1 | Pull-down enable for the host interrupt pad |
| stateCode | output | 2 | Readable charge-state code |
| faultCode | output | 3 | Readable fault code |

## Verification
The assertions check on every cycle that any fault edge pulls both lines low on the next clock, that the counter loads its full width on a restart and then counts down by one each cycle, and that an active fault forces state 11 (and code 001 for over-voltage). Some behaviours show only in the bench scenarios, which a behavioural model follows cycle by cycle:
- the exact end of a pulse,
- the absence of a retrigger while a fault stays high,
- a restart that stretches the pulse past its first end,
- the gating by the status-enable bit,
- the full priority order of the fault codes.

// File: rtl/chg_stat_pkg.sv
package chg_stat_pkg;
  localparam int FAULT_NUM    = 5;
  localparam int FAULT_CODE_W = $clog2(FAULT_NUM + 1);

  typedef enum logic [1:0] {
    ST_READY    = 2'b00,
    ST_CHARGING = 2'b01,
    ST_DONE     = 2'b10,
    ST_FAULT    = 2'b11
  } stateCodeT;

  typedef struct packed {
    logic                    restartPulse;
    logic                    enLoad;
    logic                    enValue;
    logic [1:0]              nextState;
    logic [FAULT_CODE_W-1:0] nextFault;
  } ctrlStrobeT;
endpackage

// File: rtl/chg_stat_ctrl.sv
module chg_stat_ctrl
  import chg_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           phaseIn,
  input  logic [FAULT_NUM-1:0] faultIn,
  input  logic                 statEnWrite,
  input  logic                 statEnData,
  output ctrlStrobeT           strobe
);
  logic [FAULT_NUM-1:0]    faultSeen;
  logic [FAULT_NUM-1:0]    faultRise;
  logic [FAULT_CODE_W-1:0] prioCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultSeen <= '0;
    else       faultSeen <= faultIn;
  end

  // Per-input rising edges, one detector per fault line
  for (genvar g = 0; g < FAULT_NUM; g++) begin : gRise
    assign faultRise[g] = faultIn[g] & ~faultSeen[g];
  end

  // Lowest index wins; code is index plus one
  always_comb begin
    prioCode = '0;
    for (int i = FAULT_NUM - 1; i >= 0; i--) begin
      if (faultIn[i]) prioCode = FAULT_CODE_W'(i + 1);
    end
  end

  always_comb begin
    strobe.restartPulse = |faultRise;
    strobe.enLoad       = statEnWrite;
    strobe.enValue      = statEnData;
    strobe.nextState    = (|faultIn) ? ST_FAULT : phaseIn;
    strobe.nextFault    = prioCode;
  end
endmodule

// File: rtl/chg_stat_dp.sv
module chg_stat_dp
  import chg_stat_pkg::*;
#(
  parameter int PULSE_CYCLES = 6400
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobeT              strobe,
  output logic                    pullDown,
  output logic [1:0]              stateCode,
  output logic [FAULT_CODE_W-1:0] faultCode
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] pulseCnt;
  logic             statEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt  <= '0;
      statEnQ   <= 1'b1;
      stateCode <= ST_READY;
      faultCode <= '0;
    end else begin
      if (strobe.restartPulse)  pulseCnt <= CNT_FULL;
      else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
      if (strobe.enLoad)        statEnQ  <= strobe.enValue;
      stateCode <= strobe.nextState;
      faultCode <= strobe.nextFault;
    end
  end

  // Fault pulse has priority over the steady charging level
  assign pullDown = (pulseCnt != '0) || (statEnQ && stateCode == ST_CHARGING);

  assert_pulse_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restartPulse |=> pulseCnt == CNT_FULL);

  assert_pulse_decay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restartPulse && pulseCnt != '0) |=> pulseCnt == $past(pulseCnt) - 1'b1);

  assert_pulse_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restartPulse && pulseCnt == '0) |=> pulseCnt == '0);
endmodule

// File: rtl/chg_stat_out.sv
module chg_stat_out
  import chg_stat_pkg::*;
#(
  parameter int PULSE_CYCLES = 6400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] phaseIn,
  input  logic [4:0] faultIn,
  input  logic       statEnWrite,
  input  logic       statEnData,
  output logic       ledPullDown,
  output logic       irqPullDown,
  output logic [1:0] stateCode,
  output logic [2:0] faultCode
);
  ctrlStrobeT strobe;
  logic       pullDown;

  chg_stat_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .phaseIn     (phaseIn),
    .faultIn     (faultIn),
    .statEnWrite (statEnWrite),
    .statEnData  (statEnData),
    .strobe      (strobe)
  );

  chg_stat_dp #(.PULSE_CYCLES(PULSE_CYCLES)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pullDown  (pullDown),
    .stateCode (stateCode),
    .faultCode (faultCode)
  );

  assign ledPullDown = pullDown;
  assign irqPullDown = pullDown;

  assert_edge_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(faultIn & ~$past(faultIn))) |=> (ledPullDown && irqPullDown));

  assert_fault_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|faultIn) |=> stateCode == 2'b11);

  assert_ovp_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultIn[0] |=> faultCode == 3'b001);
endmodule

// File: tb/test_chg_stat_out.sv
module test_chg_stat_out;
  localparam int P = 200;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] phaseIn;
  logic [4:0] faultIn;
  logic       statEnWrite;
  logic       statEnData;
  logic       ledPullDown;
  logic       irqPullDown;
  logic [1:0] stateCode;
  logic [2:0] faultCode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int         remain;
  logic [4:0] prevF;
  logic       enM;
  logic [1:0] stM;
  logic [2:0] fcM;

  always #10 clk = ~clk;

  chg_stat_out #(.PULSE_CYCLES(P)) i_chg_stat_out (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .faultIn(faultIn),
    .statEnWrite(statEnWrite), .statEnData(statEnData),
    .ledPullDown(ledPullDown), .irqPullDown(irqPullDown),
    .stateCode(stateCode), .faultCode(faultCode));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #6;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // model update at each edge, compare away from the edge
  always @(posedge clk) begin
    if (!rstN) begin
      remain = 0; prevF = '0; enM = 1'b1; stM = 2'b00; fcM = 3'b000;
    end else begin
      if ((faultIn & ~prevF) != 5'b0) remain = P;
      else if (remain > 0)            remain--;
      prevF = faultIn;
      if (statEnWrite) enM = statEnData;
      stM = (faultIn != 5'b0) ? 2'b11 : phaseIn;
      fcM = 3'b000;
      for (int i = 4; i >= 0; i--) if (faultIn[i]) fcM = 3'(i + 1);
    end
    #5;
    if (!done) begin
      check("R2/R6 led pull-down per cycle", ledPullDown, int'((remain > 0) || (enM && stM == 2'b01)));
      check("R2/R6 irq pull-down per cycle", irqPullDown, int'((remain > 0) || (enM && stM == 2'b01)));
      check("R4 state code per cycle", stateCode, stM);
      check("R5 fault code per cycle", faultCode, fcM);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog cycles=%0d expected<=150000", cycles);
      summary();
    end
  end

  initial begin
    rstN = 1'b0; phaseIn = 2'b00; faultIn = '0; statEnWrite = 1'b0; statEnData = 1'b0;
    step(3);
    check("R1 reset led", ledPullDown, 0);
    check("R1 reset irq", irqPullDown, 0);
    check("R1 reset state", stateCode, 0);
    check("R1 reset fault", faultCode, 0);
    @(negedge clk) rstN = 1'b1;

    // R2 and R3 default enable
    @(negedge clk) phaseIn = 2'b01;
    step(1);
    check("R2 charging pulls led low", ledPullDown, 1);
    check("R3 enable defaults to 1", irqPullDown, 1);
    @(negedge clk) phaseIn = 2'b10;
    step(1);
    check("R2 done floats", ledPullDown, 0);
    @(negedge clk) phaseIn = 2'b00;
    step(1);
    check("R2 ready floats", ledPullDown, 0);

    // R3 enable cleared
    @(negedge clk) begin statEnWrite = 1'b1; statEnData = 1'b0; phaseIn = 2'b01; end
    @(negedge clk) statEnWrite = 1'b0;
    step(2);
    check("R3 disabled charging floats", ledPullDown, 0);
    check("R4 charging state code", stateCode, 1);
    @(negedge clk) begin statEnWrite = 1'b1; statEnData = 1'b1; end
    @(negedge clk) statEnWrite = 1'b0;
    step(1);
    check("R3 re-enabled charging low", ledPullDown, 1);
    @(negedge clk) phaseIn = 2'b00;

    // R6 R7 R9 over-voltage pulse
    @(negedge clk) faultIn = 5'b00001;
    step(1);
    check("R4 fault state code", stateCode, 3);
    check("R5 over-voltage code", faultCode, 1);
    check("R6 pulse starts", ledPullDown, 1);
    step(P - 1);
    check("R6 pulse last cycle", irqPullDown, 1);
    step(1);
    check("R7 pulse ended floats", ledPullDown, 0);
    step(2 * P);
    check("R7 held fault no retrigger", ledPullDown, 0);
    @(negedge clk) faultIn = 5'b00000;
    step(1);
    check("R9 state code back", stateCode, 0);
    check("R9 fault code back", faultCode, 0);

    // R5 priority
    @(negedge clk) faultIn = 5'b00110;
    step(1);
    check("R5 sleep over undervoltage", faultCode, 2);
    @(negedge clk) faultIn = 5'b00100;
    step(1);
    check("R5 undervoltage code", faultCode, 3);
    @(negedge clk) faultIn = 5'b01000;
    step(1);
    check("R5 thermal code", faultCode, 4);
    @(negedge clk) faultIn = 5'b10000;
    step(1);
    check("R5 timer code", faultCode, 5);
    @(negedge clk) faultIn = 5'b00000;
    step(P + 2);
    check("R7 float after pulse", ledPullDown, 0);

    // R8 restart, with enable off (R6)
    @(negedge clk) begin statEnWrite = 1'b1; statEnData = 1'b0; end
    @(negedge clk) begin statEnWrite = 1'b0; faultIn = 5'b00010; end
    step(P / 2);
    check("R6 pulse ignores enable", ledPullDown, 1);
    @(negedge clk) faultIn = 5'b10010;
    step(1);
    step(P - 1);
    check("R8 restarted pulse still low", ledPullDown, 1);
    step(1);
    check("R8 restarted pulse ends", irqPullDown, 0);
    @(negedge clk) faultIn = 5'b00000;
    step(2);
    check("R9 codes normal", stateCode, 0);

    done = 1'b1;
    summary();
  end
endmodule